// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block takes a free-running source clock and produces two outputs from it. The first is a gated copy that a stop request can halt. The second is a companion copy that the stop request never touches. The stop request is asynchronous and active low. It passes through a synchronizer that runs on the falling edge of the source. The gating enable then changes only while the source is low. As a result, the gated output always parks at logic 0 and always comes back with a complete high phase.

A parameter picks the timing flavour. Bus-style timing acts one rising edge after the request has been synchronized. Processor-style timing adds a short pipeline of extra stages, and the total latency stays under four source cycles. The block counts how long the request stays high and raises a sticky flag when an enabled interval ends before the minimum allowed length. That minimum is 10 cycles in bus-style timing and 100 cycles in processor-style timing. A global power-down input forces both outputs low at once, and the stop request has no effect while it is asserted.

Top module: `clk_stop_gate`

## Requirements
- R1: `stop_n` passes through SYNC_STAGES (default 2) flops clocked on the falling edge of `clk_src` before it acts. A value sampled at falling edge k therefore cannot affect `clk_gated` before the rising edge that follows falling edge k+1.
- R2: While the group is stopped, `clk_gated` is held at 0. `clk_gated` is never 1 while `clk_src` is 0.
- R3: The gating enable changes only while `clk_src` is low. Every high phase of `clk_gated` is therefore a complete high phase of `clk_src`.
- R4: With MODE = TIMING_PCI, take a `stop_n` value sampled at falling edge k. `clk_gated` follows that value, 1 = running and 0 = stopped, starting with the first rising edge after falling edge k+1.
- R5: With MODE = TIMING_CPU, take a `stop_n` value sampled at falling edge k. `clk_gated` follows that value starting with the first rising edge after falling edge k+1+CPU_EXTRA. CPU_EXTRA defaults to 2, which gives a latency below 4 cycles.
- R6: `clk_free` follows `clk_src` whatever the value of `stop_n`, unless power-down is in effect.
- R7: `min_en_viol` is set when a run of consecutive falling-edge samples with `stop_n` high ends before it reaches MIN samples (MIN is 10 for TIMING_PCI and 100 for TIMING_CPU). A run of exactly MIN samples does not set it.
- R8: Once `min_en_viol` is set, it stays set until reset.
- R9: While `pwr_dn` is 1, `clk_gated` and `clk_free` are 0 at once. Pulses on `stop_n` during that time do not set `min_en_viol`. After `pwr_dn` is sampled low at a falling edge, both outputs resume with full high phases from the next rising edge.
- R10: When `rst` (active high) is sampled at a falling edge, the synchronizer is cleared to the stopped state, `min_en_viol` is cleared, and `clk_gated` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| stop_n | input | 1 | Asynchronous stop request, active low |
| pwr_dn | input | 1 | Global power-down, active high |
| clk_gated | output | 1 | Stoppable clock output |
| clk_free | output | 1 | Free-running companion clock |
| min_en_viol | output | 1 | Sticky flag for an enabled interval that was too short |

## Verification
The bench drives a bus-style instance and a processor-style instance with the same stimulus. It records `stop_n` at every falling edge and predicts the gated output for each high phase from the stated latency. A design with an extra or a missing synchronizer or pipeline stage would therefore show a shift of one phase. The bench also checks every low phase, so a gate that parked high or that switched during a high phase would show up as a stray pulse. Enabled runs are placed at exactly MIN and at one cycle short of MIN in each mode, which catches an off-by-one in the interval counter. A short pulse is sent during power-down, which exposes a monitor that fails to ignore the request there. A second reset shows whether the flag actually clears.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

  typedef enum logic {
    TIMING_PCI = 1'b0,
    TIMING_CPU = 1'b1
  } timing_e;

endpackage

// File: rtl/cg_sync.sv
// Falling-edge synchronizer chain; resets to the "stopped" value 0.
module cg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(negedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cg_delay.sv
// Optional extra falling-edge stages for processor-style latency.
module cg_delay #(
  parameter int DEPTH = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_pass
      logic [0:0] unused_clk;
      assign unused_clk = {clk & rst};
      assign q = d;
    end else if (DEPTH == 1) begin : g_one
      logic stage;
      always_ff @(negedge clk) begin
        if (rst) stage <= 1'b0;
        else     stage <= d;
      end
      assign q = stage;
    end else begin : g_many
      logic [DEPTH-1:0] stages;
      always_ff @(negedge clk) begin
        if (rst) stages <= '0;
        else     stages <= {stages[DEPTH-2:0], d};
      end
      assign q = stages[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/cg_min_en_mon.sv
// Measures each enabled run of the synchronized request; sticky flag on short runs.
module cg_min_en_mon #(
  parameter int MIN_CNT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic req,
  output logic viol
);
  localparam int CW = $clog2(MIN_CNT + 1);

  logic          req_d;
  logic [CW-1:0] run_len;

  always_ff @(negedge clk) begin
    if (rst) begin
      req_d   <= 1'b0;
      run_len <= '0;
      viol    <= 1'b0;
    end else if (hold) begin
      req_d   <= req;
      run_len <= '0;
    end else begin
      req_d <= req;
      if (req) begin
        if (run_len != CW'(MIN_CNT)) run_len <= run_len + 1'b1;
      end else begin
        run_len <= '0;
      end
      if (req_d && !req && (run_len < CW'(MIN_CNT))) viol <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter clk_gate_pkg::timing_e MODE = clk_gate_pkg::TIMING_PCI,
  parameter int SYNC_STAGES = 2,
  parameter int CPU_EXTRA   = 2,
  parameter int PCI_MIN_EN  = 10,
  parameter int CPU_MIN_EN  = 100
) (
  input  logic clk_src,
  input  logic rst,
  input  logic stop_n,
  input  logic pwr_dn,
  output logic clk_gated,
  output logic clk_free,
  output logic min_en_viol
);
  localparam bit IS_CPU = (MODE == clk_gate_pkg::TIMING_CPU);
  localparam int DELAY  = IS_CPU ? CPU_EXTRA : 0;
  localparam int MIN_EN = IS_CPU ? CPU_MIN_EN : PCI_MIN_EN;

  logic req_sync;
  logic gate_en;
  logic pd_q;

  cg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_src), .rst(rst), .d_async(stop_n), .q(req_sync)
  );

  cg_delay #(.DEPTH(DELAY)) u_delay (
    .clk(clk_src), .rst(rst), .d(req_sync), .q(gate_en)
  );

  cg_min_en_mon #(.MIN_CNT(MIN_EN)) u_mon (
    .clk(clk_src), .rst(rst), .hold(pd_q), .req(req_sync), .viol(min_en_viol)
  );

  // Power-down is registered on the low phase so that release gives a full pulse.
  always_ff @(negedge clk_src) begin
    if (rst) pd_q <= 1'b0;
    else     pd_q <= pwr_dn;
  end

  assign clk_gated = clk_src & gate_en & ~pd_q & ~pwr_dn;
  assign clk_free  = clk_src & ~pd_q & ~pwr_dn;
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter clk_gate_pkg::timing_e MODE = clk_gate_pkg::TIMING_PCI,
  parameter int SYNC_STAGES = 2,
  parameter int CPU_EXTRA   = 2
) (
  input logic clk_src,
  input logic rst,
  input logic stop_n,
  input logic pwr_dn,
  input logic clk_gated,
  input logic clk_free,
  input logic min_en_viol,
  input logic gate_en,
  input logic pd_q
);
  localparam int LAT = SYNC_STAGES + ((MODE == clk_gate_pkg::TIMING_CPU) ? CPU_EXTRA : 0);

  logic [3:0] settle;
  always_ff @(negedge clk_src) begin
    if (rst)              settle <= '0;
    else if (settle != 4'd15) settle <= settle + 4'd1;
  end

  // R2
  gated_park_chk: assert property (@(negedge clk_src) disable iff (rst)
    !gate_en |-> !clk_gated);

  // R3
  always @(gate_en) begin
    if (!rst) en_low_change_chk: assert (clk_src !== 1'b1);
  end

  // R4 R5 R1
  latency_chk: assert property (@(negedge clk_src) disable iff (rst)
    (settle > 4'(LAT)) |-> (gate_en == $past(stop_n, LAT)));

  // R6
  free_run_chk: assert property (@(negedge clk_src) disable iff (rst)
    (!pwr_dn && !pd_q) |-> clk_free);

  // R9
  pd_low_chk: assert property (@(negedge clk_src) disable iff (rst)
    pwr_dn |-> (!clk_gated && !clk_free));

  // R8
  viol_sticky_chk: assert property (@(negedge clk_src) disable iff (rst)
    min_en_viol |=> min_en_viol);

  // R10
  rst_clear_chk: assert property (@(negedge clk_src)
    rst |=> !min_en_viol);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .MODE(MODE), .SYNC_STAGES(SYNC_STAGES), .CPU_EXTRA(CPU_EXTRA)
) u_chk (
  .clk_src(clk_src), .rst(rst), .stop_n(stop_n), .pwr_dn(pwr_dn),
  .clk_gated(clk_gated), .clk_free(clk_free), .min_en_viol(min_en_viol),
  .gate_en(gate_en), .pd_q(pd_q)
);

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/100ps
module clk_stop_gate_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_n = 1'b0;
  logic pwr_dn = 1'b0;
  logic g_pci, f_pci, v_pci, g_cpu, f_cpu, v_cpu;
  int total = 0;
  int bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_stop_gate #(.MODE(clk_gate_pkg::TIMING_PCI)) uut (
    .clk_src(clk), .rst(rst), .stop_n(stop_n), .pwr_dn(pwr_dn),
    .clk_gated(g_pci), .clk_free(f_pci), .min_en_viol(v_pci)
  );

  clk_stop_gate #(.MODE(clk_gate_pkg::TIMING_CPU)) uut_cpu (
    .clk_src(clk), .rst(rst), .stop_n(stop_n), .pwr_dn(pwr_dn),
    .clk_gated(g_cpu), .clk_free(f_cpu), .min_en_viol(v_cpu)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Falling-edge history of the request: hist[0] is the newest sample.
  logic [7:0] hist = '0;
  logic pdh = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      hist <= '0;
      pdh  <= 1'b0;
    end else begin
      hist <= {hist[6:0], stop_n};
      pdh  <= pwr_dn;
    end
  end

  // High-phase model: R1 two sync stages, R4 no extra, R5 two extra stages.
  always @(posedge clk) begin
    #1;
    if (chk_on) begin
      logic pd_any;
      pd_any = pwr_dn | pdh;
      chk(pd_any ? "R9 gated pci" : "R4 R3 gated pci", g_pci, hist[1] & ~pd_any);
      chk(pd_any ? "R9 gated cpu" : "R5 R3 gated cpu", g_cpu, hist[3] & ~pd_any);
      chk(pd_any ? "R9 free pci" : "R6 free pci", f_pci, ~pd_any);
      chk(pd_any ? "R9 free cpu" : "R6 free cpu", f_cpu, ~pd_any);
    end
  end

  // Low-phase model: R2 nothing may be high.
  always @(negedge clk) begin
    #1;
    if (chk_on) begin
      chk("R2 low pci", g_pci, 1'b0);
      chk("R2 low cpu", g_cpu, 1'b0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk_on = 1'b1;
    // R10 reset state
    chk("R10 viol pci", v_pci, 1'b0);
    chk("R10 viol cpu", v_cpu, 1'b0);
    chk("R10 gated pci", g_pci, 1'b0);
    rst = 1'b0;
    cyc(2);
    stop_n = 1'b1;
    cyc(120);
    stop_n = 1'b0;
    cyc(20);
    chk("R7 long run pci", v_pci, 1'b0);
    chk("R7 long run cpu", v_cpu, 1'b0);
    // exactly MIN for bus style, short for processor style
    stop_n = 1'b1;
    cyc(10);
    stop_n = 1'b0;
    cyc(10);
    chk("R7 run10 pci", v_pci, 1'b0);
    chk("R7 run10 cpu", v_cpu, 1'b1);
    stop_n = 1'b1;
    cyc(9);
    stop_n = 1'b0;
    cyc(10);
    chk("R7 run9 pci", v_pci, 1'b1);
    stop_n = 1'b1;
    cyc(150);
    stop_n = 1'b0;
    cyc(5);
    chk("R8 sticky pci", v_pci, 1'b1);
    chk("R8 sticky cpu", v_cpu, 1'b1);
    // second reset
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R10 clear pci", v_pci, 1'b0);
    chk("R10 clear cpu", v_cpu, 1'b0);
    cyc(2);
    stop_n = 1'b1;
    cyc(100);
    stop_n = 1'b0;
    cyc(10);
    chk("R7 run100 cpu", v_cpu, 1'b0);
    // power-down with a short request pulse inside it
    stop_n = 1'b1;
    cyc(20);
    pwr_dn = 1'b1;
    cyc(3);
    stop_n = 1'b0;
    cyc(2);
    stop_n = 1'b1;
    cyc(2);
    stop_n = 1'b0;
    cyc(4);
    pwr_dn = 1'b0;
    cyc(6);
    chk("R9 ignored pci", v_pci, 1'b0);
    chk("R9 ignored cpu", v_cpu, 1'b0);
    stop_n = 1'b1;
    cyc(30);
    pwr_dn = 1'b1;
    cyc(4);
    pwr_dn = 1'b0;
    cyc(10);
    stop_n = 1'b0;
    cyc(10);
    stop_n = 1'b1;
    cyc(99);
    stop_n = 1'b0;
    cyc(10);
    chk("R7 run99 cpu", v_cpu, 1'b1);
    chk("R7 run99 pci", v_pci, 1'b0);
    cyc(5);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule